// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt requests from up to eleven peripheral sources into a status register and combines them with a software-programmed mask to drive one interrupt line towards the CPU. Sources raise their status bit with a one-cycle pulse. Software clears a pending source by writing a word in which that bit is zero; the bits it writes as one are kept only if they are also enabled in the mask. Two sources (the serial port, bit 7, and the sound unit, bit 9) also present a level signal. While that level is high, the bit is set again at the moment of a status write, before the clearing is applied. Bit 3 carries the DMA interrupt.

Software reaches both registers through a small request channel that uses valid/ready. The controller always accepts, so `req_ready` is held high and the requester never waits. A read returns its data on the response channel in the cycle after it is accepted. The response has no ready signal, so the requester must always be able to take it. Writes return no response.

Top module: `irq_stat_mask_ctrl`

## Requirements
- R1: After reset the status and mask registers are 0, `irq_out` is 0, `rsp_valid` is 0, and `req_ready` is 1.
- R2: A pulse on `src_pulse[i]` sets status bit i at the next clock edge. The bit then stays set until a status write clears it.
- R3: A write to the status register (byte offset 0x070) loads status := status AND mask AND wdata[10:0], using the register values from before the write. A 0 in wdata acknowledges that bit.
- R4: At a status write, bit 7 is set first if `lvl_serial` is high, and bit 9 is set first if `lvl_sound` is high. The AND of R3 is then applied.
- R5: If a source pulse arrives in the same cycle as a status write, the pulse wins and the bit is set after the edge.
- R6: A write to the mask register (byte offset 0x074) loads mask := wdata[10:0]. `irq_out` equals the OR of (status AND mask) over the register values, so it rises in the cycle after a mask write that leaves an overlap.
- R7: A read accepted at edge k gives `rsp_valid`=1 after edge k, holding the register value from before that edge. Bits 31..11 of the response are always 0. Reads of any other offset return 0, including a 16-bit read of an upper half (0x072 or 0x076).
- R8: Accesses take `req_size` 0 for 16 bits or 1 for 32 bits. A write with either size to any offset other than 0x070 or 0x074 changes neither register, and this includes the upper halves 0x072 and 0x076.
- R9: `req_ready` is 1 in every cycle after reset, and each valid request is accepted in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = 16-bit, 1 = 32-bit |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| src_pulse | input | 11 | Per-source request pulses |
| lvl_serial | input | 1 | Level of the serial source (bit 7) |
| lvl_sound | input | 1 | Level of the sound source (bit 9) |
| irq_out | output | 1 | CPU interrupt line |

## Verification
The acknowledging status write and a new source pulse can fall in the same cycle. The same is true of a status write and a high level on one of the two level sources. The bench provokes both on purpose: directed steps fire a pulse together with a write of zero, and a long random phase drives pulses, levels and writes freely so that they collide often. A behavioural model in the bench computes status, mask, the interrupt line and every read response cycle by cycle, and each output is judged against that model after every clock.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned OFS_W = 12;
  localparam logic [OFS_W-1:0] STAT_OFS = 12'h070;
  localparam logic [OFS_W-1:0] MASK_OFS = 12'h074;

  typedef enum logic {
    ACC_16 = 1'b0,
    ACC_32 = 1'b1
  } acc_size_e;

  typedef struct packed {
    logic stat_wr;
    logic mask_wr;
    logic stat_rd;
    logic mask_rd;
  } reg_hit_t;
endpackage

// File: rtl/icu_decode.sv
module icu_decode
  import icu_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              valid,
  input  logic              write,
  input  logic              size,
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit
);
  logic at_stat, at_mask;

  // Both sizes hit only at the aligned word offset; a 16-bit access
  // there covers the low half, which holds every implemented bit.
  assign at_stat = (addr == ADDR_W'(STAT_OFS)) &&
                   (size == ACC_32 || size == ACC_16);
  assign at_mask = (addr == ADDR_W'(MASK_OFS));

  always_comb begin
    hit = '0;
    if (valid) begin
      hit.stat_wr = write  && at_stat;
      hit.mask_wr = write  && at_mask;
      hit.stat_rd = !write && at_stat;
      hit.mask_rd = !write && at_mask;
    end
  end

  always_comb begin
    a_r8_onehot_hit: assert ($onehot0(hit));
  end
endmodule

// File: rtl/icu_status.sv
module icu_status #(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned SER_BIT = 7,
  parameter int unsigned SND_BIT = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] mask,
  input  logic [NUM_SRC-1:0] pulse,
  input  logic               lvl_ser,
  input  logic               lvl_snd,
  output logic [NUM_SRC-1:0] status
);
  logic [NUM_SRC-1:0] lvl_vec, status_q, status_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
    if (i == SER_BIT) begin : g_ser
      assign lvl_vec[i] = lvl_ser;
    end else if (i == SND_BIT) begin : g_snd
      assign lvl_vec[i] = lvl_snd;
    end else begin : g_none
      assign lvl_vec[i] = 1'b0;
    end
  end

  always_comb begin
    status_d = status_q;
    if (wr) status_d = (status_q | lvl_vec) & mask & wdata;
    status_d = status_d | pulse;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status = status_q;

  // R2: with no write and no pulse the pending bits stay put
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && pulse == '0) |=> $stable(status_q));
  // R5: a pulse always lands, even against an acknowledge
  a_r5_pulse_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse != '0) |=> ((status_q & $past(pulse)) == $past(pulse)));
  // R3: after a write nothing survives outside mask AND data, except new pulses
  a_r3_ack_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ((status_q & ~$past(pulse) & ~($past(mask) & $past(wdata))) == '0));
endmodule

// File: rtl/icu_mask.sv
module icu_mask #(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)  mask <= '0;
    else if (wr) mask <= wdata;
  end

  // R6: a mask write loads exactly the written bits
  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (mask == $past(wdata)));
  // R8: without a write the mask never moves
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mask));
endmodule

// File: rtl/irq_stat_mask_ctrl.sv
module irq_stat_mask_ctrl
  import icu_pkg::*;
#(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned SER_BIT = 7,
  parameter int unsigned SND_BIT = 9,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_size,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               lvl_serial,
  input  logic               lvl_sound,
  output logic               irq_out
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  reg_hit_t           hit;
  logic [NUM_SRC-1:0] status, mask, wbits, rd_bits;
  logic               unused_hi;

  assign req_ready = 1'b1;
  assign wbits     = req_wdata[NUM_SRC-1:0];
  assign unused_hi = ^req_wdata[DATA_W-1:NUM_SRC];

  icu_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid(req_valid), .write(req_write), .size(req_size),
    .addr(req_addr), .hit(hit)
  );

  icu_status #(.NUM_SRC(NUM_SRC), .SER_BIT(SER_BIT), .SND_BIT(SND_BIT)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr(hit.stat_wr), .wdata(wbits), .mask(mask),
    .pulse(src_pulse), .lvl_ser(lvl_serial), .lvl_snd(lvl_sound),
    .status(status)
  );

  icu_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(hit.mask_wr), .wdata(wbits), .mask(mask)
  );

  always_comb begin
    rd_bits = '0;
    if (hit.stat_rd) rd_bits = status;
    if (hit.mask_rd) rd_bits = mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_data  <= {{PAD_W{1'b0}}, rd_bits};
    end
  end

  assign irq_out = |(status & mask);

  // R6: a mask write that overlaps pending status raises the line next cycle
  a_r6_irq_after_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (hit.mask_wr && ((status & wbits) != '0)) |=> irq_out);
  // R7: every accepted read is answered one cycle later
  a_r7_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  // R7: the unimplemented upper bits are always zero
  a_r7_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data[DATA_W-1:NUM_SRC] == '0));
  // R9: never back-pressure
  a_r9_ready: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
endmodule

// File: tb/tb_irq_stat_mask_ctrl.sv
module tb_irq_stat_mask_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [10:0] src_pulse = '0;
  logic        lvl_serial = 1'b0, lvl_sound = 1'b0;
  logic        req_ready, rsp_valid, irq_out;
  logic [31:0] rsp_data;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  // behavioural reference state
  logic [10:0] m_stat = '0, m_mask = '0;
  logic        m_rv = 1'b0;
  logic [31:0] m_rd = '0;

  always #2ns clk = ~clk;

  irq_stat_mask_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .src_pulse(src_pulse), .lvl_serial(lvl_serial), .lvl_sound(lvl_sound),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // reference model, updated at each rising edge from the stable inputs
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_stat = '0; m_mask = '0; m_rv = 1'b0; m_rd = '0;
    end else begin
      logic [10:0] lv;
      m_rv = req_valid && !req_write;
      m_rd = 32'h0;
      if (req_addr == 12'h070) m_rd = {21'h0, m_stat};
      if (req_addr == 12'h074) m_rd = {21'h0, m_mask};
      lv = {1'b0, lvl_sound, 1'b0, lvl_serial, 7'h0};
      if (req_valid && req_write && req_addr == 12'h070)
        m_stat = (m_stat | lv) & m_mask & req_wdata[10:0];
      if (req_valid && req_write && req_addr == 12'h074)
        m_mask = req_wdata[10:0];
      m_stat = m_stat | src_pulse;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 irq_out", {31'h0, irq_out}, {31'h0, |(m_stat & m_mask)});
      chk("R7 rsp_valid", {31'h0, rsp_valid}, {31'h0, m_rv});
      if (m_rv) chk("R7 rsp_data", rsp_data, m_rd);
      chk("R9 req_ready", {31'h0, req_ready}, 32'h1);
    end
  end

  task automatic issue(input logic v, input logic w, input logic sz,
                       input logic [11:0] a, input logic [31:0] d,
                       input logic [10:0] p);
    @(negedge clk);
    req_valid = v; req_write = w; req_size = sz; req_addr = a;
    req_wdata = d; src_pulse = p;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; src_pulse = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic sz, input logic [31:0] d);
    issue(1'b1, 1'b1, sz, a, d, 11'h0);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic sz,
                        input logic [31:0] exp);
    issue(1'b1, 1'b0, sz, a, 32'h0, 11'h0);
    chk(req, rsp_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 irq after reset", {31'h0, irq_out}, 32'h0);
    chk("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    chk("R9 ready after reset", {31'h0, req_ready}, 32'h1);
    rd_chk("R1 status reset", 12'h070, 1'b1, 32'h0);
    rd_chk("R1 mask reset", 12'h074, 1'b1, 32'h0);
    // R2 pulse sets and holds
    issue(1'b0, 1'b0, 1'b0, 12'h0, 32'h0, 11'h008);
    repeat (3) @(negedge clk);
    rd_chk("R2 pulse held", 12'h070, 1'b1, 32'h008);
    // R6 mask write raises irq next cycle
    wr(12'h074, 1'b1, 32'h0000_0008);
    chk("R6 irq after mask", {31'h0, irq_out}, 32'h1);
    // R3 ack by zero
    wr(12'h070, 1'b1, 32'h0);
    rd_chk("R3 ack clears", 12'h070, 1'b1, 32'h0);
    chk("R3 irq dropped", {31'h0, irq_out}, 32'h0);
    // R3 mask gating on write of ones
    issue(1'b0, 1'b0, 1'b0, 12'h0, 32'h0, 11'h00B);
    wr(12'h070, 1'b0, 32'h07FF);
    rd_chk("R3 masked bits dropped", 12'h070, 1'b0, 32'h008);
    // R4 level re-set of bits 7 and 9
    wr(12'h074, 1'b1, 32'h280);
    lvl_serial = 1'b1;
    wr(12'h070, 1'b1, 32'h7FF);
    rd_chk("R4 serial level re-set", 12'h070, 1'b1, 32'h080);
    lvl_serial = 1'b0; lvl_sound = 1'b1;
    wr(12'h070, 1'b1, 32'h7FF);
    rd_chk("R4 sound level re-set", 12'h070, 1'b1, 32'h280);
    wr(12'h070, 1'b1, 32'h0);
    rd_chk("R4 ack despite level", 12'h070, 1'b1, 32'h0);
    lvl_sound = 1'b0;
    // R5 pulse against acknowledge
    wr(12'h074, 1'b1, 32'hFFFF_FFFF);
    issue(1'b1, 1'b1, 1'b1, 12'h070, 32'h0, 11'h020);
    rd_chk("R5 pulse wins", 12'h070, 1'b0, 32'h020);
    // R7 read shapes
    rd_chk("R7 mask high bits zero", 12'h074, 1'b1, 32'h7FF);
    rd_chk("R7 upper half reads zero", 12'h072, 1'b0, 32'h0);
    rd_chk("R7 other offset zero", 12'h100, 1'b1, 32'h0);
    // R8 ignored writes
    wr(12'h076, 1'b0, 32'h0);
    wr(12'h078, 1'b1, 32'h0);
    wr(12'h072, 1'b0, 32'h0);
    rd_chk("R8 mask untouched", 12'h074, 1'b1, 32'h7FF);
    rd_chk("R8 status untouched", 12'h070, 1'b1, 32'h020);
    // random collisions of pulses, levels and accesses
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] pick;
      logic [11:0] a;
      @(negedge clk);
      pick = 3'($urandom_range(0, 4));
      case (pick)
        3'd0: a = 12'h070;
        3'd1: a = 12'h072;
        3'd2: a = 12'h074;
        3'd3: a = 12'h076;
        default: a = 12'h100;
      endcase
      req_valid  = ($urandom_range(0, 2) != 0);
      req_write  = $urandom_range(0, 1) == 1;
      req_size   = $urandom_range(0, 1) == 1;
      req_addr   = a;
      req_wdata  = $urandom;
      src_pulse  = ($urandom_range(0, 3) == 0) ? 11'($urandom) : 11'h0;
      lvl_serial = $urandom_range(0, 1) == 1;
      lvl_sound  = $urandom_range(0, 1) == 1;
    end
    @(negedge clk);
    req_valid = 1'b0; src_pulse = '0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule